// File: doc/BRIEF.md
# Burst Write Deserializer with CRC Check

This block sits behind a debug scan chain and turns the serial data of a burst-write transfer into parallel bus writes. Once the command decoder has captured the word size, the start address and the word count, it pulses `arm`. The block then watches TDI during the shift phase. It skips leading zeros until it sees a single 1 start bit. After that it assembles words LSB first and hands each one to a request/acknowledge write port, with the address advancing by the word size. One status bit is returned on TDO after every word.

A single holding register sits between the serial side and the bus. The next word can therefore shift in while the previous write is still waiting for its acknowledge. If a word finishes while that register is still occupied, the word is dropped and its status bit reads 0. The block then stops until it is armed again, so the host can restart from that word.

After the last word, 32 CRC bits follow, LSB first. The block answers with one bit that says whether they match the CRC it computed over the received data bits. A bus error seen on an acknowledge raises a sticky error flag and records the address of the failing write.

Top module: `burst_wr_deser`

## Requirements
- R1: After `arm`, TDI zeros are ignored while `shift_en` is high. The first 1 is the start bit, and the first data bit follows it on the next shift cycle.
- R2: The word width is set by `cfg_size`: code 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Bits arrive LSB first. `bus_data` carries the word zero-extended in its low bits.
- R3: There are `cfg_count` words (at least 1). The first word is written at `cfg_addr`, and each accepted word adds 1, 2 or 4 bytes to the address according to the word size.
- R4: In the shift cycle after the last bit of each word, TDO carries a status bit. The value 1 means the word entered the holding register.
- R5: A word is dropped if the holding register is full and not acknowledged in the cycle the word completes. Its status bit is then 0, the pending word is still written unchanged, and the block produces no more writes and keeps TDO at 0 until the next `arm`.
- R6: After the last word's status cycle, 32 CRC bits are taken LSB first. In the next shift cycle TDO is 1 if they equal the CRC of all data bits, and 0 otherwise. The CRC starts at 0xFFFFFFFF and, for each bit, shifts right and XORs in 0xEDB88320 when the data bit XOR the old LSB is 1.
- R7: A `bus_err` together with `bus_ack` sets `err_flag` and latches the address of that write in `err_addr`. Later errors do not change either of them, and `err_clr` clears the flag.
- R8: While the block is not armed (after reset or after the CRC result), TDI has no effect: TDO stays 0 and no bus request is made.
- R9: While `bus_req` is high without `bus_ack`, `bus_req`, `bus_addr` and `bus_data` hold steady.
- R10: After reset, TDO, `bus_req` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse: latch the configuration and wait for a start bit |
| cfg_size | input | 2 | Word size code (0: 8 bits, 1: 16 bits, 2/3: 32 bits) |
| cfg_addr | input | AW | Start address of the burst |
| cfg_count | input | CNTW | Number of words in the burst |
| shift_en | input | 1 | High in cycles where a TDI bit is shifted |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Status bit or CRC match bit |
| bus_req | output | 1 | Write request pending |
| bus_addr | output | AW | Write address |
| bus_data | output | 32 | Write data, zero-extended |
| bus_size | output | 2 | Word size code of the write |
| bus_ack | input | 1 | Write accepted |
| bus_err | input | 1 | Write failed (valid with bus_ack) |
| err_clr | input | 1 | Clears the error flag |
| err_flag | output | 1 | Sticky bus error flag |
| err_addr | output | AW | Address of the first failed write |

## Verification
The bench places the start bit after different numbers of leading zeros and checks the first word's data. A design that counted from the shift entry would return that word shifted. It holds back the acknowledge long enough that a second 8-bit word completes against a full holding register. A wrong design would then either overwrite the pending data or report status 1 and keep writing. It also corrupts one CRC bit, to catch a match bit stuck at 1, and injects two bus errors in a row, to catch an error address that is not held from the first failure.

// File: rtl/burst_wr_deser.sv
module burst_wr_deser #(
  parameter int AW   = 32,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [1:0]      cfg_size,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CNTW-1:0] cfg_count,
  input  logic            shift_en,
  input  logic            tdi,
  output logic            tdo,
  output logic            bus_req,
  output logic [AW-1:0]   bus_addr,
  output logic [31:0]     bus_data,
  output logic [1:0]      bus_size,
  input  logic            bus_ack,
  input  logic            bus_err,
  input  logic            err_clr,
  output logic            err_flag,
  output logic [AW-1:0]   err_addr
);
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_DATA, S_STAT, S_CRC, S_MATCH, S_HALT} st_t;

  st_t             state;
  logic [4:0]      bitcnt;
  logic [31:0]     shreg, crc, rxcrc, wvec;
  logic [CNTW-1:0] left;
  logic [AW-1:0]   nxt_addr;
  logic [1:0]      size;
  logic            stat_bit, match_bit, buf_valid;
  logic [31:0]     buf_data;
  logic [AW-1:0]   buf_addr;

  wire [4:0]    last_idx = (size == 2'd0) ? 5'd7 : (size == 2'd1) ? 5'd15 : 5'd31;
  wire [AW-1:0] step     = (size == 2'd0) ? AW'(1) : (size == 2'd1) ? AW'(2) : AW'(4);
  wire          word_fin = shift_en && state == S_DATA && bitcnt == last_idx;
  wire          drop     = buf_valid && !bus_ack;
  wire [31:0]   crc_nx   = (crc >> 1) ^ (((crc[0] ^ tdi) == 1'b1) ? POLY : 32'h0);
  wire [31:0]   rx_nx    = {tdi, rxcrc[31:1]};

  always_comb begin
    wvec = shreg;
    wvec[bitcnt] = tdi;
  end

  assign tdo      = (state == S_STAT) ? stat_bit : (state == S_MATCH) ? match_bit : 1'b0;
  assign bus_req  = buf_valid;
  assign bus_addr = buf_addr;
  assign bus_data = buf_data;
  assign bus_size = size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; crc <= '1; rxcrc <= '0;
      left <= '0; nxt_addr <= '0; size <= '0; stat_bit <= 1'b0; match_bit <= 1'b0;
    end else if (arm) begin
      state <= S_SYNC; bitcnt <= '0; shreg <= '0; crc <= '1;
      left <= cfg_count; nxt_addr <= cfg_addr; size <= cfg_size;
    end else if (shift_en) begin
      case (state)
        S_SYNC: if (tdi) state <= S_DATA;
        S_DATA: begin
          crc <= crc_nx;
          if (bitcnt == last_idx) begin
            bitcnt   <= '0;
            shreg    <= '0;
            stat_bit <= !drop;
            state    <= S_STAT;
            if (!drop) begin
              left     <= left - 1'b1;
              nxt_addr <= nxt_addr + step;
            end
          end else begin
            shreg  <= wvec;
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_STAT: state <= !stat_bit ? S_HALT : (left == '0) ? S_CRC : S_DATA;
        S_CRC: begin
          rxcrc  <= rx_nx;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 5'd31) begin
            match_bit <= (rx_nx == crc);
            state     <= S_MATCH;
          end
        end
        S_MATCH: state <= S_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0; buf_data <= '0; buf_addr <= '0;
      err_flag <= 1'b0; err_addr <= '0;
    end else begin
      if (buf_valid && bus_ack) buf_valid <= 1'b0;
      if (word_fin && !drop) begin
        buf_valid <= 1'b1;
        buf_data  <= wvec;
        buf_addr  <= nxt_addr;
      end
      if (err_clr) err_flag <= 1'b0;
      else if (buf_valid && bus_ack && bus_err && !err_flag) begin
        err_flag <= 1'b1;
        err_addr <= buf_addr;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_data));

  p_drop_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_fin && bus_req && !bus_ack && !arm |=> !tdo && $stable(bus_data) && $stable(bus_addr));

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_err && !err_clr |=> err_flag);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag && $stable(err_addr));

  p_halt_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HALT && !arm |=> !tdo);
endmodule

// File: tb/sim_burst_wr_deser.sv
module sim_burst_wr_deser;
  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, shift_en = 1'b0, tdi = 1'b0;
  logic [1:0] cfg_size = '0;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_count = '0;
  logic bus_ack = 1'b0, bus_err = 1'b0, err_clr = 1'b0;
  logic tdo, bus_req, err_flag;
  logic [31:0] bus_addr, bus_data, err_addr;
  logic [1:0] bus_size;

  burst_wr_deser #(.AW(32), .CNTW(16)) u0 (.*);

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int ack_delay = 0, wcnt = 0, nlog = 0, err_at = -1;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always @(negedge clk) begin
    if (bus_ack) begin bus_ack = 1'b0; bus_err = 1'b0; end
    else if (bus_req) begin
      if (wcnt >= ack_delay) begin
        bus_ack = 1'b1; bus_err = (nlog == err_at);
        log_addr[nlog] = bus_addr; log_data[nlog] = bus_data;
        nlog++; wcnt = 0;
      end else wcnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // size[31:30] count[29:24] pad[23:20] corrupt[19] delay[18:16] addr[15:0]
  localparam logic [31:0] VEC [5] = '{
    {2'd0, 6'd3, 4'd2, 1'b0, 3'd0, 16'h0100},
    {2'd1, 6'd4, 4'd0, 1'b0, 3'd2, 16'h0200},
    {2'd2, 6'd2, 4'd5, 1'b0, 3'd1, 16'h1000},
    {2'd3, 6'd1, 4'd1, 1'b0, 3'd0, 16'h2000},
    {2'd2, 6'd2, 4'd0, 1'b1, 3'd0, 16'h3000}};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] wdat(input int k, input int i, input logic [1:0] sz);
    logic [31:0] v = (32'h9E3779B9 * (k * 7 + i + 1)) ^ 32'h5A5A0F0F;
    return (sz == 2'd0) ? {24'd0, v[7:0]} : (sz == 2'd1) ? {16'd0, v[15:0]} : v;
  endfunction

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d, input int n);
    logic [31:0] r = c;
    for (int b = 0; b < n; b++) r = (r >> 1) ^ (((r[0] ^ d[b]) == 1'b1) ? 32'hEDB88320 : 32'h0);
    return r;
  endfunction

  task automatic clk_bit(input logic b, output logic t);
    @(negedge clk);
    t = tdo;
    tdi = b;
    shift_en = 1'b1;
  endtask

  task automatic do_arm(input logic [1:0] sz, input int cnt, input logic [31:0] base);
    @(negedge clk);
    arm = 1'b1; cfg_size = sz; cfg_count = 16'(cnt); cfg_addr = base; shift_en = 1'b0;
    @(negedge clk);
    arm = 1'b0; shift_en = 1'b1; tdi = 1'b0;
  endtask

  task automatic do_burst(input logic [1:0] sz, input int cnt, input int pad,
                          input bit corrupt, input logic [31:0] base, input int k);
    logic t;
    logic [31:0] c = 32'hFFFFFFFF, w;
    int n0 = nlog, wb = wbits(sz), step = wb / 8;
    do_arm(sz, cnt, base);
    for (int p = 0; p < pad; p++) clk_bit(1'b0, t);
    clk_bit(1'b1, t);
    for (int i = 0; i < cnt; i++) begin
      w = wdat(k, i, sz);
      c = crc_upd(c, w, wb);
      for (int b = 0; b < wb; b++) clk_bit(w[b], t);
      clk_bit(1'b0, t);
      check(t == 1'b1, "R4 status accepted", 32'(t), 32'd1);
    end
    if (corrupt) c[5] = ~c[5];
    for (int b = 0; b < 32; b++) clk_bit(c[b], t);
    clk_bit(1'b0, t);
    check(t == !corrupt, "R6 crc match bit", 32'(t), 32'(!corrupt));
    @(negedge clk); shift_en = 1'b0;
    repeat (30) @(negedge clk);
    check(nlog - n0 == cnt, "R3 write count", 32'(nlog - n0), 32'(cnt));
    for (int i = 0; i < cnt && n0 + i < nlog; i++) begin
      check(log_addr[n0+i] == base + 32'(i * step), "R3 address step", log_addr[n0+i], base + 32'(i * step));
      check(log_data[n0+i] == wdat(k, i, sz), (pad > 0 && i == 0) ? "R1 start bit after zeros" : "R2 word assembly",
            log_data[n0+i], wdat(k, i, sz));
    end
  endtask

  initial begin
    logic t;
    int n0;
    repeat (3) @(negedge clk);
    check(tdo == 1'b0 && bus_req == 1'b0 && err_flag == 1'b0, "R10 reset state",
          {29'd0, tdo, bus_req, err_flag}, 32'd0);
    rst_n = 1'b1;

    // R8: unarmed after reset
    n0 = nlog;
    for (int i = 0; i < 40; i++) begin
      clk_bit(1'b1, t);
      if (t !== 1'b0) check(1'b0, "R8 tdo while unarmed", 32'(t), 32'd0);
    end
    @(negedge clk); shift_en = 1'b0;
    check(tdo == 1'b0 && nlog == n0 && !bus_req, "R8 no effect when unarmed", 32'(nlog - n0), 32'd0);

    for (int v = 0; v < 5; v++) begin
      ack_delay = int'(VEC[v][18:16]);
      do_burst(VEC[v][31:30], int'(VEC[v][29:24]), int'(VEC[v][23:20]), VEC[v][19],
               32'h8000_0000 | {16'd0, VEC[v][15:0]}, v);
    end

    // R8: idle after a finished burst
    n0 = nlog;
    for (int i = 0; i < 20; i++) begin
      clk_bit(1'b1, t);
      if (t !== 1'b0) check(1'b0, "R8 tdo after burst", 32'(t), 32'd0);
    end
    @(negedge clk); shift_en = 1'b0;
    repeat (5) @(negedge clk);
    check(nlog == n0, "R8 no write after burst", 32'(nlog - n0), 32'd0);

    // R5: overrun against a held-off bus
    ack_delay = 40;
    n0 = nlog;
    do_arm(2'd0, 4, 32'h4000_0010);
    clk_bit(1'b1, t);
    for (int b = 0; b < 8; b++) clk_bit(wdat(9, 0, 2'd0)[b], t);
    clk_bit(1'b0, t);
    check(t == 1'b1, "R4 first word status", 32'(t), 32'd1);
    for (int b = 0; b < 8; b++) clk_bit(wdat(9, 1, 2'd0)[b], t);
    clk_bit(1'b0, t);
    check(t == 1'b0, "R5 overrun status", 32'(t), 32'd0);
    for (int i = 0; i < 30; i++) begin
      clk_bit(1'b1, t);
      if (t !== 1'b0) check(1'b0, "R5 tdo after overrun", 32'(t), 32'd0);
    end
    @(negedge clk); shift_en = 1'b0;
    repeat (80) @(negedge clk);
    check(nlog - n0 == 1, "R5 only pending word written", 32'(nlog - n0), 32'd1);
    check(log_data[n0] == wdat(9, 0, 2'd0), "R5 pending word intact", log_data[n0], wdat(9, 0, 2'd0));
    check(log_addr[n0] == 32'h4000_0010, "R5 pending address", log_addr[n0], 32'h4000_0010);

    // R7: bus errors
    ack_delay = 0;
    err_at = nlog + 1;
    do_burst(2'd2, 3, 0, 1'b0, 32'h5000_0000, 11);
    check(err_flag == 1'b1, "R7 error flag set", 32'(err_flag), 32'd1);
    check(err_addr == 32'h5000_0004, "R7 error address", err_addr, 32'h5000_0004);
    err_at = nlog;
    do_burst(2'd1, 1, 0, 1'b0, 32'h6000_0000, 12);
    check(err_addr == 32'h5000_0004, "R7 first error kept", err_addr, 32'h5000_0004);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check(err_flag == 1'b0, "R7 error clear", 32'(err_flag), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule